// File: doc/BRIEF.md
# SDRAM Software-Driven Command Sequencer

This block drives the command pins of an SDRAM whose power-up and mode programming are run by software. A small mode register selects what the next bus write access becomes. With a command code set, each write access issues exactly one SDRAM command on the pins. Access completion is then acknowledged once the command's recovery interval has passed. With the normal code set, write accesses are passed on to the data path and no command is generated here.

The block also holds the timing configuration word and the low-power fields. The precharge and refresh recovery counts are taken from the timing word, and the low-power fields form the operand of the extended mode load. The clock enable is raised by the first NOP command. That NOP also starts the long power-up pause. A deep power-down command drops the clock enable again so the part can be parked before reset.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset the pins are deselected (sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n all 1), sd_cke is 0, sd_ba and sd_a are 0, busy and acc_ack are 0, and the mode code is 0.
- R2: With mode code 0 or 7, dp_fwd follows acc_req, no command is driven on the pins and acc_ack stays 0.
- R3: Mode code 1 makes an access issue one NOP (CS_n=0, RAS_n=1, CAS_n=1, WE_n=1), and sd_cke is 1 from that command on.
- R4: A NOP issued while sd_cke is 0 delays acc_ack by PAUSE_CYC+1 cycles after the command cycle. A NOP issued with sd_cke already 1 delays it by TRP+1 cycles.
- R5: Mode code 2 issues an all-banks precharge: RAS_n=0, CAS_n=1, WE_n=0, with sd_a bit 10 high and the other address bits 0. acc_ack follows TRP+1 cycles later.
- R6: Mode code 4 issues one auto refresh per access: RAS_n=0, CAS_n=0, WE_n=1. acc_ack follows TRC+1 cycles later, and eight back-to-back accesses give eight commands.
- R7: Mode code 3 issues a load mode register command: RAS_n, CAS_n and WE_n all 0, with sd_ba=00 and sd_a equal to acc_addr. acc_ack follows TRP+1 cycles later.
- R8: Mode code 5 issues an extended mode load with the same pin encoding, sd_ba=10 and sd_a equal to the low-power word zero-extended. Its fields are PASR in bits 2:0, TCSR in bits 4:3 and drive strength in bits 6:5. acc_ack follows TRP+1 cycles later.
- R9: Mode code 6 issues a deep power-down: RAS_n=1, CAS_n=1, WE_n=0, with sd_cke falling in the same cycle. acc_ack follows TRP+1 cycles later.
- R10: Each command lasts one cycle and the pins are deselected in every other cycle. busy is 1 from the command cycle until acc_ack. An access request held during busy produces no further command.
- R11: Register writes use cfg_sel: 0 for the mode code (bits 2:0), 1 for the timing word, 2 for the low-power word. The written value appears on timing_cfg or lowpwr_cfg on the next cycle. TRP is timing bits 3:0 and TRC is bits 7:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 mode, 1 timing, 2 low-power) |
| cfg_wdata | input | 32 | Register write data |
| acc_req | input | 1 | Bus write access request, held until acknowledged |
| acc_addr | input | A_W | Access address |
| acc_ack | output | 1 | One-cycle completion of a command access |
| busy | output | 1 | Command issued, recovery interval running |
| dp_fwd | output | 1 | Access forwarded to the data path (normal mode) |
| timing_cfg | output | 32 | Stored timing configuration word |
| lowpwr_cfg | output | 7 | Stored low-power fields |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | A_W | Address bus |

## Verification
The software power-up order is run in full: a first NOP with the clock still stopped, a second NOP, a precharge, eight refreshes, a mode load with a chosen address and an extended mode load. These steps tell the pause count apart from the precharge count and the refresh count, and they separate the two mode-load bank codes. A deep power-down followed by a fresh NOP shows that the clock enable falls and that the long pause is re-armed. Requests held high through every wait, and stretches in modes 0 and 7, confirm that repeated or normal-mode accesses never reach the pins.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int A_W       = 13,
  parameter int PAUSE_CYC = 50000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [1:0]     cfg_sel,
  input  logic [31:0]    cfg_wdata,
  input  logic           acc_req,
  input  logic [A_W-1:0] acc_addr,
  output logic           acc_ack,
  output logic           busy,
  output logic           dp_fwd,
  output logic [31:0]    timing_cfg,
  output logic [6:0]     lowpwr_cfg,
  output logic           sd_cke,
  output logic           sd_cs_n,
  output logic           sd_ras_n,
  output logic           sd_cas_n,
  output logic           sd_we_n,
  output logic [1:0]     sd_ba,
  output logic [A_W-1:0] sd_a
);
  localparam int DMAX = (PAUSE_CYC > 15) ? PAUSE_CYC : 15;
  localparam int CW   = $clog2(DMAX + 1);

  logic [2:0]     mode_q;
  logic [31:0]    tcfg_q;
  logic [6:0]     lp_q;
  logic           wait_q, ack_q, cke_q, cs_q;
  logic [CW-1:0]  cnt_q, dly;
  logic [2:0]     rcw_q, rcw;
  logic [1:0]     ba_q, ba;
  logic [A_W-1:0] a_q, a;
  logic           cke_nx;

  wire special = (mode_q >= 3'd1) && (mode_q <= 3'd6);
  wire start   = acc_req && !wait_q && special;
  wire [3:0] trp = tcfg_q[3:0];
  wire [3:0] trc = tcfg_q[7:4];

  assign dp_fwd     = acc_req && !special;
  assign busy       = wait_q;
  assign acc_ack    = ack_q;
  assign timing_cfg = tcfg_q;
  assign lowpwr_cfg = lp_q;
  assign sd_cke     = cke_q;
  assign sd_cs_n    = cs_q;
  assign {sd_ras_n, sd_cas_n, sd_we_n} = rcw_q;
  assign sd_ba      = ba_q;
  assign sd_a       = a_q;

  always_comb begin
    rcw    = 3'b111;
    ba     = 2'b00;
    a      = '0;
    dly    = CW'(trp);
    cke_nx = cke_q;
    case (mode_q)
      3'd1: begin
        cke_nx = 1'b1;
        dly    = cke_q ? CW'(trp) : CW'(PAUSE_CYC);
      end
      3'd2: begin
        rcw = 3'b010;
        a   = A_W'(1024);
      end
      3'd3: begin
        rcw = 3'b000;
        a   = acc_addr;
      end
      3'd4: begin
        rcw = 3'b001;
        dly = CW'(trc);
      end
      3'd5: begin
        rcw = 3'b000;
        ba  = 2'b10;
        a   = A_W'(lp_q);
      end
      3'd6: begin
        rcw    = 3'b110;
        cke_nx = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      tcfg_q <= '0;
      lp_q   <= '0;
    end else if (cfg_wr) begin
      case (cfg_sel)
        2'd0:    mode_q <= cfg_wdata[2:0];
        2'd1:    tcfg_q <= cfg_wdata;
        2'd2:    lp_q   <= cfg_wdata[6:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      ack_q  <= 1'b0;
      cnt_q  <= '0;
      cke_q  <= 1'b0;
      cs_q   <= 1'b1;
      rcw_q  <= 3'b111;
      ba_q   <= 2'b00;
      a_q    <= '0;
    end else begin
      ack_q <= 1'b0;
      cs_q  <= 1'b1;
      rcw_q <= 3'b111;
      ba_q  <= 2'b00;
      a_q   <= '0;
      if (start) begin
        wait_q <= 1'b1;
        cnt_q  <= dly;
        cke_q  <= cke_nx;
        cs_q   <= 1'b0;
        rcw_q  <= rcw;
        ba_q   <= ba;
        a_q    <= a;
      end else if (wait_q) begin
        if (cnt_q == '0) begin
          wait_q <= 1'b0;
          ack_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
  parameter int A_W = 13
) (
  input logic           clk,
  input logic           rst_n,
  input logic           acc_ack,
  input logic           busy,
  input logic           dp_fwd,
  input logic           sd_cke,
  input logic           sd_cs_n,
  input logic           sd_ras_n,
  input logic           sd_cas_n,
  input logic           sd_we_n,
  input logic [1:0]     sd_ba,
  input logic [A_W-1:0] sd_a
);
  AST_SINGLE_CYCLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |=> sd_cs_n); // R10
  AST_CMD_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |-> busy); // R10
  AST_ACK_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack |-> !busy); // R10
  AST_NORMAL_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    dp_fwd |=> sd_cs_n); // R2
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n) |-> sd_a[10]); // R5
  AST_MODE_LOAD_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n) |-> (sd_ba == 2'b00 || sd_ba == 2'b10)); // R7
  AST_CKE_RISE_ON_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_cke) |-> (!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n)); // R3
  AST_CKE_FALL_ON_DPD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_cke) |-> (!sd_cs_n && sd_ras_n && sd_cas_n && !sd_we_n)); // R9
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(.A_W(A_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_ack(acc_ack), .busy(busy), .dp_fwd(dp_fwd),
  .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
  .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a));

// File: tb/sim_sdram_cmd_seq.sv
module sim_sdram_cmd_seq;
  localparam int A_W = 13;
  localparam int PAUSE = 40;
  localparam int TRP = 3;
  localparam int TRC = 6;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, acc_req = 0;
  logic [1:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic [A_W-1:0] acc_addr = 0;
  logic acc_ack, busy, dp_fwd, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [31:0] timing_cfg;
  logic [6:0] lowpwr_cfg;
  logic [1:0] sd_ba;
  logic [A_W-1:0] sd_a;

  always #2 clk = ~clk;

  sdram_cmd_seq #(.A_W(A_W), .PAUSE_CYC(PAUSE)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .acc_req(acc_req), .acc_addr(acc_addr), .acc_ack(acc_ack), .busy(busy), .dp_fwd(dp_fwd),
    .timing_cfg(timing_cfg), .lowpwr_cfg(lowpwr_cfg), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a));

  typedef struct {
    logic [2:0] rcw;
    logic [1:0] ba;
    logic [A_W-1:0] a;
    logic cke;
    int dly;
    string req;
  } exp_t;

  exp_t expq[$];
  exp_t cur;
  int n_chk = 0, n_bad = 0;
  bit active = 0, done = 0;
  int wcnt = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic access(input logic [A_W-1:0] addr, input logic [2:0] rcw,
                        input logic [1:0] ba, input logic [A_W-1:0] a,
                        input logic cke, input int dly, input string req);
    exp_t e;
    e.rcw = rcw; e.ba = ba; e.a = a; e.cke = cke; e.dly = dly; e.req = req;
    expq.push_back(e);
    @(negedge clk);
    acc_req = 1; acc_addr = addr;
    @(negedge clk);
    chk(busy === 1'b1, "R10 busy after command", longint'(busy), 1);
    while (acc_ack !== 1'b1) @(negedge clk);
    acc_req = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sd_cs_n === 1'b0) begin
        if (expq.size() == 0) begin
          chk(0, "R10 unexpected command", longint'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
        end else begin
          cur = expq.pop_front();
          chk({sd_ras_n, sd_cas_n, sd_we_n} === cur.rcw, cur.req,
              longint'({sd_ras_n, sd_cas_n, sd_we_n}), longint'(cur.rcw));
          chk(sd_ba === cur.ba, cur.req, longint'(sd_ba), longint'(cur.ba));
          chk(sd_a === cur.a, cur.req, longint'(sd_a), longint'(cur.a));
          chk(sd_cke === cur.cke, cur.req, longint'(sd_cke), longint'(cur.cke));
          active = 1;
          wcnt = 0;
        end
      end else if (active) begin
        if (acc_ack === 1'b1) begin
          chk(wcnt == cur.dly, {cur.req, " ack delay"}, longint'(wcnt), longint'(cur.dly));
          active = 0;
        end else begin
          wcnt++;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic normal_window(input string req);
    @(negedge clk);
    acc_req = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(dp_fwd === 1'b1 && sd_cs_n === 1'b1 && acc_ack === 1'b0, req,
          longint'({dp_fwd, sd_cs_n, acc_ack}), 3'b110);
    end
    acc_req = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} === 4'hF, "R1 pins", longint'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 15);
    chk(sd_cke === 1'b0 && busy === 1'b0 && acc_ack === 1'b0, "R1 cke/busy/ack", longint'({sd_cke, busy, acc_ack}), 0);
    chk(sd_ba === 2'b00 && sd_a === '0, "R1 ba/a", longint'({sd_ba, sd_a}), 0);

    normal_window("R2 mode 0 forwards");

    wr_reg(2'd1, 32'h4B2A_1163);
    chk(timing_cfg === 32'h4B2A_1163, "R11 timing word", longint'(timing_cfg), 32'h4B2A_1163);
    wr_reg(2'd2, 32'h0000_004D);
    chk(lowpwr_cfg === 7'h4D, "R11 low-power word", longint'(lowpwr_cfg), 7'h4D);

    wr_reg(2'd0, 32'd1);
    access(13'h1F0, 3'b111, 2'b00, '0, 1'b1, PAUSE, "R3 R4 first NOP");
    access(13'h0A0, 3'b111, 2'b00, '0, 1'b1, TRP, "R4 later NOP");

    wr_reg(2'd0, 32'd2);
    access(13'h055, 3'b010, 2'b00, A_W'(1024), 1'b1, TRP, "R5 precharge");

    wr_reg(2'd0, 32'd4);
    for (int k = 0; k < 8; k++)
      access(A_W'(k * 8), 3'b001, 2'b00, '0, 1'b1, TRC, "R6 auto refresh");

    wr_reg(2'd0, 32'd3);
    access(13'h0032, 3'b000, 2'b00, 13'h0032, 1'b1, TRP, "R7 mode load");

    wr_reg(2'd0, 32'd5);
    access(13'h1555, 3'b000, 2'b10, 13'h004D, 1'b1, TRP, "R8 extended mode load");

    wr_reg(2'd0, 32'd6);
    access(13'h0000, 3'b110, 2'b00, '0, 1'b0, TRP, "R9 deep power-down");
    @(negedge clk);
    chk(sd_cke === 1'b0, "R9 cke stays low", longint'(sd_cke), 0);

    wr_reg(2'd0, 32'd1);
    access(13'h0000, 3'b111, 2'b00, '0, 1'b1, PAUSE, "R4 NOP after power-down");

    wr_reg(2'd0, 32'd7);
    normal_window("R2 mode 7 forwards");

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R10 all commands seen", longint'(expq.size()), 0);
    finish_run();
  end
endmodule